// File: doc/BRIEF.md
# Multiply-Based Cache Slice and Set Mapper

This block turns a physical byte address into a placement in a sliced last-level cache: a slice number, a set index inside that slice, and the tag to be stored. The slice count need not be a power of two and is supplied at run time. The mapper does not take the set from low address bits and XOR-fold the upper bits into a slice number. Instead it takes a window of line-address bits, multiplies it by the slice count, and reads both slice and set out of the product. Every slice and every set of the configured capacity is then reachable, and consecutive lines spread evenly across the whole structure.

A second mode keeps the conventional set index, taken directly from the address. In that mode only the slice comes from a small multiply of the bits above the set field, so the stored tag can be shorter. A request travels through a single registered stage using a valid/ready handshake. An input beat transfers when `in_valid` and `in_ready` are both high. An output beat transfers when `out_valid` and `out_ready` are both high. While the output is stalled it holds its value and the input is not accepted. One request can complete per cycle when the output is not stalled.

Top module: `cslm_mapper`

## Requirements
- R1: An input is accepted on a rising edge with in_valid and in_ready both high, and its result appears with out_valid high one cycle later. in_ready is high whenever out_valid is low or out_ready is high, so one request per cycle is sustained.
- R2: While out_valid is high and out_ready is low, out_slice, out_set and out_tag hold their values, out_valid stays high and in_ready is low.
- R3: The mapping field is the N_SETS_LOG2+T address bits starting at bit 6. Bits 5..0 (the offset within a 64-byte line) have no effect on any output.
- R4: The slice_count input is T bits wide. A code of 0 means 2^T slices, and any other code means that many slices.
- R5: In mixed mode (raw_set_mode=0), x is the field multiplied by the slice count. out_slice is x shifted right by N_SETS_LOG2+T and is always less than the slice count.
- R6: In mixed mode, out_set is bits N_SETS_LOG2+T-1 down to T of x.
- R7: In mixed mode, out_tag is address bits PA_WIDTH-1 down to 6.
- R8: In raw mode (raw_set_mode=1), out_set is address bits 6+N_SETS_LOG2-1 down to 6. out_slice is the T address bits directly above those, multiplied by the slice count and shifted right by T.
- R9: In raw mode, out_tag holds address bits PA_WIDTH-1 down to 6+N_SETS_LOG2 in its low bits and zeros above them.
- R10: With one slice, mixed mode gives slice 0 and takes the set from the top N_SETS_LOG2 field bits. With 2^T slices, mixed mode takes the slice from the top T field bits and the set from the low N_SETS_LOG2 field bits.
- R11: In mixed mode, a sweep over all 2^(N_SETS_LOG2+T) consecutive line addresses gives each slice a hit count within 1 of 2^(N_SETS_LOG2+T)/s. Each reachable (slice, set) pair gets a hit count within 1 of 2^T/s, and no pair with a slice of s or more is hit.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Mapper can take a request |
| in_addr | input | PA_WIDTH | Physical byte address |
| slice_count | input | T | Number of slices, 0 meaning 2^T |
| raw_set_mode | input | 1 | 1: set from raw address bits; 0: mixed set |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_slice | output | T | Slice number |
| out_set | output | N_SETS_LOG2 | Set index in the slice |
| out_tag | output | PA_WIDTH-6 | Tag to store |

## Verification
The even-spread property is the hardest to reach from the ports. It only shows up once every line in the full mapping window has been pushed through, and the default geometry makes that window far too long for a short run. The bench therefore adds a second, small instance with 4 set bits and 3 slice bits. Through it, the bench streams all 128 consecutive lines back to back for several slice counts, including a count that is not a power of two. It tallies the outputs per slice and per (slice, set) pair. A stalled output with a different request waiting at the input is built on purpose, so that the hold and the later acceptance can both be seen.

// File: rtl/cslm_pkg.sv
package cslm_pkg;
  localparam int LINE_OFFSET_BITS = 6;

  typedef enum logic {
    MAP_MIXED   = 1'b0,
    MAP_RAW_SET = 1'b1
  } map_mode_e;
endpackage

// File: rtl/cslm_count_decode.sv
module cslm_count_decode #(
  parameter int T = 6
) (
  input  logic [T-1:0] count_code,
  output logic [T:0]   count_eff
);
  // a zero code selects the full power-of-two population
  always_comb begin
    if (count_code == '0) count_eff = {1'b1, {T{1'b0}}};
    else                  count_eff = {1'b0, count_code};
  end
endmodule

// File: rtl/cslm_scale_mul.sv
module cslm_scale_mul #(
  parameter int A_W           = 17,
  parameter int B_W           = 7,
  parameter bit USE_SHIFT_ADD = 1'b0
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  localparam int P_W = A_W + B_W;

  generate
    if (USE_SHIFT_ADD) begin : g_shift_add
      logic [P_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < B_W; i++) begin
          if (b[i]) acc = acc + (P_W'(a) << i);
        end
      end
      assign p = acc;
    end else begin : g_operator
      assign p = P_W'(a) * P_W'(b);
    end
  endgenerate
endmodule

// File: rtl/cslm_map_core.sv
module cslm_map_core #(
  parameter int N_SETS_LOG2   = 11,
  parameter int T             = 6,
  parameter int PA_WIDTH      = 46,
  parameter bit USE_SHIFT_ADD = 1'b0
) (
  input  logic [PA_WIDTH-1:0]                           addr,
  input  logic [T:0]                                    count_eff,
  input  cslm_pkg::map_mode_e                           mode,
  output logic [T-1:0]                                  slice,
  output logic [N_SETS_LOG2-1:0]                        set_idx,
  output logic [PA_WIDTH-cslm_pkg::LINE_OFFSET_BITS-1:0] tag
);
  localparam int OFF       = cslm_pkg::LINE_OFFSET_BITS;
  localparam int FIELD_W   = N_SETS_LOG2 + T;
  localparam int WIDE_W    = FIELD_W + T + 1;
  localparam int SMALL_W   = 2 * T + 1;
  localparam int TAG_W     = PA_WIDTH - OFF;
  localparam int RAW_TAG_W = TAG_W - N_SETS_LOG2;

  logic [FIELD_W-1:0] field;
  logic [T-1:0]       hi_bits;
  logic [WIDE_W-1:0]  wide_p;
  logic [SMALL_W-1:0] small_p;

  assign field   = addr[OFF +: FIELD_W];
  assign hi_bits = addr[OFF+N_SETS_LOG2 +: T];

  // field times slice count: slice in the top bits, set below them
  cslm_scale_mul #(.A_W(FIELD_W), .B_W(T+1), .USE_SHIFT_ADD(USE_SHIFT_ADD)) u_wide (
    .a(field), .b(count_eff), .p(wide_p)
  );

  // only the bits above the raw set field are scaled in raw mode
  cslm_scale_mul #(.A_W(T), .B_W(T+1), .USE_SHIFT_ADD(USE_SHIFT_ADD)) u_small (
    .a(hi_bits), .b(count_eff), .p(small_p)
  );

  logic [T-1:0]           mix_slice, raw_slice;
  logic [N_SETS_LOG2-1:0] mix_set, raw_set;
  logic [TAG_W-1:0]       mix_tag, raw_tag;

  assign mix_slice = wide_p[FIELD_W +: T];
  assign mix_set   = wide_p[T +: N_SETS_LOG2];
  assign mix_tag   = addr[PA_WIDTH-1:OFF];

  assign raw_slice = small_p[T +: T];
  assign raw_set   = addr[OFF +: N_SETS_LOG2];
  assign raw_tag   = {{N_SETS_LOG2{1'b0}}, addr[PA_WIDTH-1 -: RAW_TAG_W]};

  always_comb begin
    unique case (mode)
      cslm_pkg::MAP_RAW_SET: begin
        slice   = raw_slice;
        set_idx = raw_set;
        tag     = raw_tag;
      end
      default: begin
        slice   = mix_slice;
        set_idx = mix_set;
        tag     = mix_tag;
      end
    endcase
  end

  // product bits that never carry information once slice < count holds
  logic unused_bits;
  assign unused_bits = ^{wide_p[WIDE_W-1], wide_p[T-1:0], small_p[SMALL_W-1],
                         small_p[T-1:0], addr[OFF-1:0]};
endmodule

// File: rtl/cslm_out_stage.sv
module cslm_out_stage #(
  parameter int W = 57
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      data_q <= in_data;
    end
  end
endmodule

// File: rtl/cslm_mapper.sv
module cslm_mapper #(
  parameter int N_SETS_LOG2   = 11,
  parameter int T             = 6,
  parameter int PA_WIDTH      = 46,
  parameter bit USE_SHIFT_ADD = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PA_WIDTH-1:0]    in_addr,
  input  logic [T-1:0]           slice_count,
  input  logic                   raw_set_mode,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [T-1:0]           out_slice,
  output logic [N_SETS_LOG2-1:0] out_set,
  output logic [PA_WIDTH-7:0]    out_tag
);
  localparam int TAG_W = PA_WIDTH - cslm_pkg::LINE_OFFSET_BITS;
  localparam int RES_W = T + N_SETS_LOG2 + TAG_W;

  logic [T:0]             count_eff;
  logic [T-1:0]           c_slice;
  logic [N_SETS_LOG2-1:0] c_set;
  logic [TAG_W-1:0]       c_tag;
  logic [RES_W-1:0]       res_d, res_q;
  cslm_pkg::map_mode_e    mode;

  assign mode = cslm_pkg::map_mode_e'(raw_set_mode);

  cslm_count_decode #(.T(T)) u_dec (
    .count_code(slice_count), .count_eff(count_eff)
  );

  cslm_map_core #(
    .N_SETS_LOG2(N_SETS_LOG2), .T(T), .PA_WIDTH(PA_WIDTH), .USE_SHIFT_ADD(USE_SHIFT_ADD)
  ) u_core (
    .addr(in_addr), .count_eff(count_eff), .mode(mode),
    .slice(c_slice), .set_idx(c_set), .tag(c_tag)
  );

  assign res_d = {c_slice, c_set, c_tag};

  cslm_out_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign {out_slice, out_set, out_tag} = res_q;
endmodule

// File: rtl/cslm_mapper_chk.sv
module cslm_mapper_chk #(
  parameter int N_SETS_LOG2   = 11,
  parameter int T             = 6,
  parameter int PA_WIDTH      = 46,
  parameter bit USE_SHIFT_ADD = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [PA_WIDTH-1:0]    in_addr,
  input logic [T-1:0]           slice_count,
  input logic                   raw_set_mode,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [T-1:0]           out_slice,
  input logic [N_SETS_LOG2-1:0] out_set,
  input logic [PA_WIDTH-7:0]    out_tag
);
  logic [T:0]                   cnt_q;
  logic                         raw_q;
  logic [N_SETS_LOG2-1:0]       low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
      low_q <= '0;
    end else if (in_valid && in_ready) begin
      cnt_q <= (slice_count == '0) ? {1'b1, {T{1'b0}}} : {1'b0, slice_count};
      raw_q <= raw_set_mode;
      low_q <= in_addr[6 +: N_SETS_LOG2];
    end
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);                                   // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);                      // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slice)
      && $stable(out_set) && $stable(out_tag)));                // R2
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);                   // R2
  AST_SLICE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_slice} < cnt_q));                 // R5
  AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && raw_q) |-> (out_set == low_q));               // R8
  AST_SINGLE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt_q == 1) |-> (out_slice == '0));           // R10
endmodule

bind cslm_mapper cslm_mapper_chk #(
  .N_SETS_LOG2(N_SETS_LOG2), .T(T), .PA_WIDTH(PA_WIDTH), .USE_SHIFT_ADD(USE_SHIFT_ADD)
) u_chk (.*);

// File: tb/sim_cslm_mapper.sv
`timescale 1ns/1ps
module sim_cslm_mapper;
  localparam int N  = 11;
  localparam int T  = 6;
  localparam int PA = 46;
  localparam int TW = PA - 6;
  localparam int FW = N + T;
  localparam int SN = 4;
  localparam int ST = 3;
  localparam int SP = 16;
  localparam int STW = SP - 6;
  localparam int SFW = SN + ST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic          in_valid = 1'b0, raw_mode = 1'b0, out_ready = 1'b1;
  logic [PA-1:0] in_addr = '0;
  logic [T-1:0]  scount = 6'd1;
  logic          in_ready, out_valid;
  logic [T-1:0]  out_slice;
  logic [N-1:0]  out_set;
  logic [TW-1:0] out_tag;

  cslm_mapper #(.N_SETS_LOG2(N), .T(T), .PA_WIDTH(PA)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .slice_count(scount), .raw_set_mode(raw_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_slice(out_slice), .out_set(out_set), .out_tag(out_tag)
  );

  logic           s_valid = 1'b0;
  logic [SP-1:0]  s_addr = '0;
  logic [ST-1:0]  s_count = 3'd1;
  logic           s_in_ready, s_out_valid;
  logic [ST-1:0]  s_slice;
  logic [SN-1:0]  s_set;
  logic [STW-1:0] s_tag;

  cslm_mapper #(.N_SETS_LOG2(SN), .T(ST), .PA_WIDTH(SP), .USE_SHIFT_ADD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_in_ready),
    .in_addr(s_addr), .slice_count(s_count), .raw_set_mode(1'b0),
    .out_valid(s_out_valid), .out_ready(1'b1),
    .out_slice(s_slice), .out_set(s_set), .out_tag(s_tag)
  );

  function automatic logic [63:0] ref_map(logic [PA-1:0] a, logic [T-1:0] code, logic mode);
    logic [63:0] f, se, x, hi, sl, st, tg;
    f  = 64'(a[6 +: FW]);
    se = (code == '0) ? (64'd1 << T) : 64'(code);
    if (!mode) begin
      x  = f * se;
      sl = x >> FW;
      st = (x >> T) & ((64'd1 << N) - 1);
      tg = 64'(a[PA-1:6]);
    end else begin
      hi = 64'(a[6+N +: T]);
      sl = (hi * se) >> T;
      st = 64'(a[6 +: N]);
      tg = 64'(a[PA-1:6+N]);
    end
    return {7'd0, sl[T-1:0], st[N-1:0], tg[TW-1:0]};
  endfunction

  function automatic logic [63:0] got();
    return {7'd0, out_slice, out_set, out_tag};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R12 out_valid after reset", 64'(out_valid), 64'd0);
    check("R12 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_random_stream(input int n);
    logic [63:0] exp_q = '0;
    bit          have  = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (have) begin
        check("R1 stream valid", 64'(out_valid), 64'd1);
        check(raw_mode ? "R8/R9 raw map" : "R5/R6/R7 mixed map", got(), exp_q);
      end
      in_addr  = {$urandom(), $urandom()};
      scount   = 6'($urandom());
      raw_mode = 1'($urandom());
      in_valid = 1'b1;
      exp_q    = ref_map(in_addr, scount, raw_mode);
      have     = 1'b1;
    end
    @(negedge clk);
    check(raw_mode ? "R8/R9 raw map" : "R5/R6/R7 mixed map", got(), exp_q);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 idle after drain", 64'(out_valid), 64'd0);
  endtask

  task automatic send_one(input logic [PA-1:0] a, input logic [T-1:0] c, input logic m);
    @(negedge clk);
    in_addr = a; scount = c; raw_mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_offset();
    logic [PA-1:0] base = {14'h2A5, 17'h0F0F3, 15'h0, 6'h00};
    logic [63:0]   first;
    send_one(base, 6'd5, 1'b0);
    first = got();
    for (int k = 1; k < 64; k += 21) begin
      send_one(base | PA'(k), 6'd5, 1'b0);
      check("R3 offset bits ignored", got(), first);
    end
  endtask

  task automatic t_count_corners();
    logic [16:0]   fld = 17'h1ABCD;
    logic [PA-1:0] a   = (PA'(23'h12345) << 23) | (PA'(fld) << 6) | PA'(6'h2A);
    send_one(a, 6'd1, 1'b0);
    check("R10 one slice", got(), {7'd0, 6'd0, fld[16:6], a[PA-1:6]});
    send_one(a, 6'd0, 1'b0);
    check("R4/R10 code 0 means 64 slices", got(), {7'd0, fld[16:11], fld[10:0], a[PA-1:6]});
    send_one(a, 6'd63, 1'b0);
    check("R4 code 63", got(), ref_map(a, 6'd63, 1'b0));
    send_one(a, 6'd0, 1'b1);
    check("R8 raw mode full count", got(), {7'd0, a[22:17], a[16:6], 11'd0, a[PA-1:17]});
    send_one({PA{1'b1}}, 6'd37, 1'b0);
    check("R5 slice below count at top field", 64'(out_slice), 64'd36);
  endtask

  task automatic t_stall();
    logic [PA-1:0] a = {$urandom(), $urandom()};
    logic [PA-1:0] b = {$urandom(), $urandom()};
    logic [63:0]   ea = ref_map(a, 6'd11, 1'b0);
    logic [63:0]   eb = ref_map(b, 6'd11, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = a; scount = 6'd11; raw_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R1 accepted into empty stage", got(), ea);
    check("R2 in_ready low on stall", 64'(in_ready), 64'd0);
    in_addr = b; raw_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 output held", got(), ea);
    check("R2 out_valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 waiting request taken on release", got(), eb);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 empty after consume", 64'(out_valid), 64'd0);
  endtask

  task automatic t_uniform(input int s);
    int slice_hits [8];
    int pair_hits [128];
    int lines = 1 << SFW;
    int pair_bad = 0;
    for (int i = 0; i < 8; i++) slice_hits[i] = 0;
    for (int i = 0; i < 128; i++) pair_hits[i] = 0;
    for (int l = 0; l <= lines; l++) begin
      @(negedge clk);
      if (s_out_valid) begin
        slice_hits[s_slice]++;
        pair_hits[{s_slice, s_set}]++;
      end
      s_valid = (l < lines);
      s_count = ST'(s);
      s_addr  = {3'b101, 7'(l), 6'(l * 7)};
    end
    @(negedge clk);
    if (s_out_valid) begin
      slice_hits[s_slice]++;
      pair_hits[{s_slice, s_set}]++;
    end
    s_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int eff = (s == 0) ? 8 : s;
      int dev = slice_hits[i] * eff - lines;
      if (i >= eff) check("R11 no hits above count", 64'(slice_hits[i]), 64'd0);
      else check("R11 slice balance", 64'(dev <= eff && dev >= -eff), 64'd1);
    end
    for (int p = 0; p < 128; p++) begin
      int eff = (s == 0) ? 8 : s;
      int dev = pair_hits[p] * eff - (1 << ST);
      if ((p >> SN) >= eff) begin
        if (pair_hits[p] != 0) pair_bad++;
      end else if (dev > eff || dev < -eff) pair_bad++;
    end
    check("R11 pair balance", 64'(pair_bad), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random_stream(300);
    t_offset();
    t_count_corners();
    t_stall();
    t_uniform(3);
    t_uniform(5);
    t_uniform(6);
    t_uniform(0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule